// File: doc/BRIEF.md
# Dual-Lane Depth-Tested Pixel Store

This block is a screen-sized store for depth and colour. Each location holds one depth value and one colour value. Rasterized fragments arrive with a screen position, a depth and a colour. A fragment replaces the stored pair only when it lies nearer, meaning its depth is strictly smaller than the depth already held at that position. The location index is the concatenation of the row and the column, so there is one entry for every screen pixel.

There are two fragment lanes. The producer may fill both lanes in the same cycle only when the two fragments cannot share a position, for example two fragments taken from one triangle. Both fragments then pass the test and are written in the same cycle, with no arbitration between them. The depth test runs as a read stage followed by a compare-and-write stage. A fragment that arrives in the cycle right after another fragment hit the same position is compared against that earlier result, not against the stale value in memory.

A clear command resets the whole store to the farthest depth and a colour of zero. A readback port lets the contents be inspected one location at a time.

Top module: `zbuf_dual`

## Requirements
- R1: Location index is {y, x}. A readback request returns that location's depth and colour, with rb_valid high, exactly one cycle after rb_req is sampled high. rb_valid is low in the cycle after rb_req is sampled low.
- R2: A fragment is written when its z is strictly less than the stored z. A fragment whose z is equal to or larger than the stored z leaves both depth and colour unchanged.
- R3: When in_ready is high, a transfer with both in_lane bits set commits both fragments. Eight fragments at distinct positions are absorbed in four consecutive cycles.
- R4: A lane whose in_lane bit is 0 has no effect on the store, whatever its data.
- R5: A fragment accepted in the cycle right after an earlier fragment to the same position is tested against that earlier fragment's outcome. This holds on either lane, in either lane order.
- R6: After clear_req is sampled high while idle, clear_busy stays high for exactly 2^(X_BITS+Y_BITS)+1 cycles. Afterwards every location reads depth all ones and colour zero.
- R7: in_ready is low exactly while clear_busy is high. A fragment presented during that time is not taken and changes nothing.
- R8: After reset, in_ready is 1, clear_busy is 0 and rb_valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Fragment transfer offered |
| in_ready | output | 1 | Store can take a transfer |
| in_lane | input | 2 | Per-lane fragment present (bit 0 is lane 0) |
| in_x | input | 2×X_BITS | Column per lane |
| in_y | input | 2×Y_BITS | Row per lane |
| in_z | input | 2×Z_BITS | Depth per lane, smaller is nearer |
| in_color | input | 2×C_BITS | Colour per lane |
| clear_req | input | 1 | Start a full clear |
| clear_busy | output | 1 | Clear in progress |
| rb_req | input | 1 | Readback request |
| rb_x | input | X_BITS | Readback column |
| rb_y | input | Y_BITS | Readback row |
| rb_valid | output | 1 | Readback data valid |
| rb_z | output | Z_BITS | Readback depth |
| rb_color | output | C_BITS | Readback colour |

## Verification
The depth test is exercised with fragments whose depth is nearer than, equal to and farther than the stored depth. This separates a strict compare from a less-or-equal compare. Paired transfers with varied depths show that both lanes commit in one cycle, and single-lane masks show that an idle lane writes nothing. Back-to-back fragments to one position, on the same lane and on crossed lanes, produce different final depths depending on whether the second fragment sees the first one's result or the stale memory word. Fragments held at the input during a clear show whether they leak into the store.

// File: rtl/zbuf_pkg.sv
package zbuf_pkg;
  localparam int ZB_LANES = 2;

  typedef enum logic [1:0] {
    ZB_IDLE  = 2'd0,
    ZB_DRAIN = 2'd1,
    ZB_SWEEP = 2'd2
  } zb_state_e;
endpackage

// File: rtl/zbuf_store.sv
// Depth and colour arrays: one write port per lane, one synchronous read
// port per lane, plus a synchronous readback port.
module zbuf_store #(
  parameter int AW    = 10,
  parameter int ZW    = 16,
  parameter int CW    = 16,
  parameter int LANES = 2
) (
  input  logic                       clk,
  input  logic [LANES-1:0]           wr_en,
  input  logic [LANES-1:0][AW-1:0]   wr_addr,
  input  logic [LANES-1:0][ZW-1:0]   wr_z,
  input  logic [LANES-1:0][CW-1:0]   wr_c,
  input  logic [LANES-1:0][AW-1:0]   rd_addr,
  output logic [LANES-1:0][ZW-1:0]   rd_z,
  input  logic                       rb_en,
  input  logic [AW-1:0]              rb_addr,
  output logic [ZW-1:0]              rb_z,
  output logic [CW-1:0]              rb_c
);
  localparam int DEPTH = 1 << AW;

  logic [ZW-1:0] z_mem [DEPTH];
  logic [CW-1:0] c_mem [DEPTH];

  always_ff @(posedge clk) begin
    for (int l = 0; l < LANES; l++) begin
      if (wr_en[l]) begin
        z_mem[wr_addr[l]] <= wr_z[l];
        c_mem[wr_addr[l]] <= wr_c[l];
      end
    end
  end

  // lane reads: old data on a same-edge write, hazards covered by forwarding
  always_ff @(posedge clk) begin
    for (int l = 0; l < LANES; l++) begin
      rd_z[l] <= z_mem[rd_addr[l]];
    end
  end

  always_ff @(posedge clk) begin
    if (rb_en) begin
      rb_z <= z_mem[rb_addr];
      rb_c <= c_mem[rb_addr];
    end
  end
endmodule

// File: rtl/zbuf_lane.sv
// Compare stage of one lane: choose the freshest reference depth, then test.
module zbuf_lane #(
  parameter int AW    = 10,
  parameter int ZW    = 16,
  parameter int LANES = 2
) (
  input  logic                     act,
  input  logic [AW-1:0]            addr,
  input  logic [ZW-1:0]            z,
  input  logic [ZW-1:0]            mem_z,
  input  logic [LANES-1:0]         fwd_act,
  input  logic [LANES-1:0][AW-1:0] fwd_addr,
  input  logic [LANES-1:0][ZW-1:0] fwd_z,
  output logic                     win,
  output logic [ZW-1:0]            res_z
);
  logic [ZW-1:0] ref_z;

  always_comb begin
    ref_z = mem_z;
    // lanes of one cycle never share an address, so at most one match
    for (int l = 0; l < LANES; l++) begin
      if (fwd_act[l] && (fwd_addr[l] == addr)) begin
        ref_z = fwd_z[l];
      end
    end
    win   = act && (z < ref_z);
    res_z = win ? z : ref_z;
  end
endmodule

// File: rtl/zbuf_clear.sv
// Clear sequencer: one drain cycle, then one location per cycle.
module zbuf_clear
  import zbuf_pkg::*;
#(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clear_req,
  output logic          busy,
  output logic          ready,
  output logic          sweep_we,
  output logic [AW-1:0] sweep_addr
);
  zb_state_e     state;
  logic [AW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ZB_IDLE;
      cnt   <= '0;
    end else begin
      case (state)
        ZB_IDLE: begin
          if (clear_req) state <= ZB_DRAIN;
        end
        ZB_DRAIN: begin
          state <= ZB_SWEEP;
          cnt   <= '0;
        end
        ZB_SWEEP: begin
          if (&cnt) state <= ZB_IDLE;
          cnt <= cnt + 1'b1;
        end
        default: state <= ZB_IDLE;
      endcase
    end
  end

  assign busy       = (state != ZB_IDLE);
  assign ready      = (state == ZB_IDLE);
  assign sweep_we   = (state == ZB_SWEEP);
  assign sweep_addr = cnt;
endmodule

// File: rtl/zbuf_dual.sv
module zbuf_dual
  import zbuf_pkg::*;
#(
  parameter int X_BITS = 5,
  parameter int Y_BITS = 5,
  parameter int Z_BITS = 16,
  parameter int C_BITS = 16
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             in_valid,
  output logic                             in_ready,
  input  logic [ZB_LANES-1:0]              in_lane,
  input  logic [ZB_LANES-1:0][X_BITS-1:0]  in_x,
  input  logic [ZB_LANES-1:0][Y_BITS-1:0]  in_y,
  input  logic [ZB_LANES-1:0][Z_BITS-1:0]  in_z,
  input  logic [ZB_LANES-1:0][C_BITS-1:0]  in_color,
  input  logic                             clear_req,
  output logic                             clear_busy,
  input  logic                             rb_req,
  input  logic [X_BITS-1:0]                rb_x,
  input  logic [Y_BITS-1:0]                rb_y,
  output logic                             rb_valid,
  output logic [Z_BITS-1:0]                rb_z,
  output logic [C_BITS-1:0]                rb_color
);
  localparam int AW = X_BITS + Y_BITS;

  logic                             accept;
  logic [ZB_LANES-1:0]              s1_act, s2_act;
  logic [ZB_LANES-1:0][AW-1:0]      s1_addr, s2_addr, rd_addr;
  logic [ZB_LANES-1:0][Z_BITS-1:0]  s1_z, s2_z, mem_z, res_z;
  logic [ZB_LANES-1:0][C_BITS-1:0]  s1_c;
  logic [ZB_LANES-1:0]              win;
  logic [ZB_LANES-1:0]              wr_en;
  logic [ZB_LANES-1:0][AW-1:0]      wr_addr;
  logic [ZB_LANES-1:0][Z_BITS-1:0]  wr_z;
  logic [ZB_LANES-1:0][C_BITS-1:0]  wr_c;
  logic                             sweep_we;
  logic [AW-1:0]                    sweep_addr;

  assign accept = in_valid && in_ready;

  zbuf_clear #(.AW(AW)) u_clear (
    .clk        (clk),
    .rst        (rst),
    .clear_req  (clear_req),
    .busy       (clear_busy),
    .ready      (in_ready),
    .sweep_we   (sweep_we),
    .sweep_addr (sweep_addr)
  );

  // read stage: issue reads and register the fragment
  always_comb begin
    for (int l = 0; l < ZB_LANES; l++) begin
      rd_addr[l] = {in_y[l], in_x[l]};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_act <= '0;
      s2_act <= '0;
    end else begin
      s1_act <= accept ? in_lane : '0;
      s2_act <= s1_act;
    end
  end

  always_ff @(posedge clk) begin
    s1_addr <= rd_addr;
    s1_z    <= in_z;
    s1_c    <= in_color;
    s2_addr <= s1_addr;
    s2_z    <= res_z;
  end

  // compare stage, one per lane, forwarding from the previous commit
  for (genvar g = 0; g < ZB_LANES; g++) begin : g_lane
    zbuf_lane #(.AW(AW), .ZW(Z_BITS), .LANES(ZB_LANES)) u_lane (
      .act      (s1_act[g]),
      .addr     (s1_addr[g]),
      .z        (s1_z[g]),
      .mem_z    (mem_z[g]),
      .fwd_act  (s2_act),
      .fwd_addr (s2_addr),
      .fwd_z    (s2_z),
      .win      (win[g]),
      .res_z    (res_z[g])
    );
  end

  // write ports: lanes, with the clear sweep borrowing lane 0
  always_comb begin
    for (int l = 0; l < ZB_LANES; l++) begin
      wr_en[l]   = win[l];
      wr_addr[l] = s1_addr[l];
      wr_z[l]    = s1_z[l];
      wr_c[l]    = s1_c[l];
    end
    if (sweep_we) begin
      wr_en[0]   = 1'b1;
      wr_addr[0] = sweep_addr;
      wr_z[0]    = '1;
      wr_c[0]    = '0;
    end
  end

  zbuf_store #(.AW(AW), .ZW(Z_BITS), .CW(C_BITS), .LANES(ZB_LANES)) u_store (
    .clk     (clk),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_z    (wr_z),
    .wr_c    (wr_c),
    .rd_addr (rd_addr),
    .rd_z    (mem_z),
    .rb_en   (rb_req),
    .rb_addr ({rb_y, rb_x}),
    .rb_z    (rb_z),
    .rb_c    (rb_color)
  );

  always_ff @(posedge clk) begin
    if (rst) rb_valid <= 1'b0;
    else     rb_valid <= rb_req;
  end
endmodule

// File: rtl/zbuf_dual_chk.sv
module zbuf_dual_chk #(
  parameter int X_BITS = 5,
  parameter int Y_BITS = 5
) (
  input logic clk,
  input logic rst,
  input logic in_ready,
  input logic clear_req,
  input logic clear_busy,
  input logic rb_req,
  input logic rb_valid
);
  localparam int AW     = X_BITS + Y_BITS;
  localparam int BUSY_N = (1 << AW) + 1;

  logic [AW+1:0] busy_cnt;

  always_ff @(posedge clk) begin
    if (rst)             busy_cnt <= '0;
    else if (clear_busy) busy_cnt <= busy_cnt + 1'b1;
    else                 busy_cnt <= '0;
  end

  p_busy_blocks_r7: assert property (@(posedge clk) disable iff (rst)
    clear_busy |-> !in_ready);

  p_idle_ready_r7: assert property (@(posedge clk) disable iff (rst)
    !clear_busy |-> in_ready);

  p_rb_valid_r1: assert property (@(posedge clk) disable iff (rst)
    rb_req |=> rb_valid);

  p_rb_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    !rb_req |=> !rb_valid);

  p_clear_start_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(clear_busy) |-> $past(clear_req));

  p_clear_len_r6: assert property (@(posedge clk) disable iff (rst)
    $fell(clear_busy) |-> (busy_cnt == (AW+2)'(BUSY_N)));

  p_clear_bound_r6: assert property (@(posedge clk) disable iff (rst)
    clear_busy |-> (busy_cnt < (AW+2)'(BUSY_N)));
endmodule

bind zbuf_dual zbuf_dual_chk #(.X_BITS(X_BITS), .Y_BITS(Y_BITS)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .in_ready   (in_ready),
  .clear_req  (clear_req),
  .clear_busy (clear_busy),
  .rb_req     (rb_req),
  .rb_valid   (rb_valid)
);

// File: tb/zbuf_dual_bench.sv
module zbuf_dual_bench;
  localparam int XB = 5;
  localparam int YB = 5;
  localparam int ZB = 16;
  localparam int CB = 16;
  localparam int AW = XB + YB;
  localparam int DEPTH = 1 << AW;

  logic                    clk = 1'b0;
  logic                    rst = 1'b1;
  logic                    in_valid = 1'b0;
  logic                    in_ready;
  logic [1:0]              in_lane = '0;
  logic [1:0][XB-1:0]      in_x = '0;
  logic [1:0][YB-1:0]      in_y = '0;
  logic [1:0][ZB-1:0]      in_z = '0;
  logic [1:0][CB-1:0]      in_color = '0;
  logic                    clear_req = 1'b0;
  logic                    clear_busy;
  logic                    rb_req = 1'b0;
  logic [XB-1:0]           rb_x = '0;
  logic [YB-1:0]           rb_y = '0;
  logic                    rb_valid;
  logic [ZB-1:0]           rb_z;
  logic [CB-1:0]           rb_color;

  logic [ZB-1:0] mz [DEPTH];
  logic [CB-1:0] mc [DEPTH];

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  zbuf_dual #(.X_BITS(XB), .Y_BITS(YB), .Z_BITS(ZB), .C_BITS(CB)) u_zbuf_dual (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_lane(in_lane), .in_x(in_x), .in_y(in_y), .in_z(in_z),
    .in_color(in_color), .clear_req(clear_req), .clear_busy(clear_busy),
    .rb_req(rb_req), .rb_x(rb_x), .rb_y(rb_y), .rb_valid(rb_valid),
    .rb_z(rb_z), .rb_color(rb_color)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic model_put(input int x, input int y, input int z, input int c);
    int a = y * (1 << XB) + x;
    if (ZB'(z) < mz[a]) begin
      mz[a] = ZB'(z);
      mc[a] = CB'(c);
    end
  endtask

  // one transfer cycle; model follows only if accepted
  task automatic send2(input logic [1:0] mask,
                       input int x0, input int y0, input int z0, input int c0,
                       input int x1, input int y1, input int z1, input int c1,
                       output bit took);
    in_valid = 1'b1;
    in_lane  = mask;
    in_x[0] = XB'(x0); in_y[0] = YB'(y0); in_z[0] = ZB'(z0); in_color[0] = CB'(c0);
    in_x[1] = XB'(x1); in_y[1] = YB'(y1); in_z[1] = ZB'(z1); in_color[1] = CB'(c1);
    took = in_ready;
    step();
    in_valid = 1'b0;
    in_lane  = '0;
    if (took) begin
      if (mask[0]) model_put(x0, y0, z0, c0);
      if (mask[1]) model_put(x1, y1, z1, c1);
    end
  endtask

  task automatic flush();
    in_valid = 1'b0;
    step();
    step();
  endtask

  task automatic rb_chk(input string req, input int x, input int y);
    int a = y * (1 << XB) + x;
    rb_req = 1'b1;
    rb_x = XB'(x);
    rb_y = YB'(y);
    step();
    rb_req = 1'b0;
    chk(req, "rb_valid", 32'(rb_valid), 32'd1);
    chk(req, $sformatf("depth at %0d,%0d", x, y), 32'(rb_z), 32'(mz[a]));
    chk(req, $sformatf("colour at %0d,%0d", x, y), 32'(rb_color), 32'(mc[a]));
  endtask

  task automatic t_reset();
    chk("R8", "in_ready", 32'(in_ready), 32'd1);
    chk("R8", "clear_busy", 32'(clear_busy), 32'd0);
    chk("R8", "rb_valid", 32'(rb_valid), 32'd0);
  endtask

  // R6 clear length and contents; R7 fragments held during the clear
  task automatic t_clear(input bit poke);
    int n = 0;
    bit bad_ready = 1'b0;
    clear_req = 1'b1;
    step();
    clear_req = 1'b0;
    if (poke) begin
      in_valid = 1'b1;
      in_lane  = 2'b11;
      in_x[0] = XB'(1); in_y[0] = YB'(1); in_z[0] = '0; in_color[0] = CB'('h1111);
      in_x[1] = XB'(2); in_y[1] = YB'(1); in_z[1] = '0; in_color[1] = CB'('h2222);
    end
    while (clear_busy && n < 4 * DEPTH) begin
      if (in_ready) bad_ready = 1'b1;
      n++;
      step();
    end
    in_valid = 1'b0;
    in_lane  = '0;
    for (int a = 0; a < DEPTH; a++) begin
      mz[a] = '1;
      mc[a] = '0;
    end
    chk("R6", "busy cycles", 32'(n), 32'(DEPTH + 1));
    chk("R7", "ready low during clear", 32'(bad_ready), 32'd0);
    chk("R7", "ready back after clear", 32'(in_ready), 32'd1);
    rb_chk("R6", 0, 0);
    rb_chk("R6", (1 << XB) - 1, (1 << YB) - 1);
    if (poke) begin
      rb_chk("R7", 1, 1);
      rb_chk("R7", 2, 1);
    end
  endtask

  // R2 strict less-than on one lane
  task automatic t_single();
    bit t;
    send2(2'b01, 3, 4, 100, 'hA1, 0, 0, 0, 0, t); flush();
    rb_chk("R2", 3, 4);
    chk("R2", "first write", 32'(rb_z), 32'd100);
    send2(2'b01, 3, 4, 100, 'hB2, 0, 0, 0, 0, t); flush();
    rb_chk("R2", 3, 4);
    chk("R2", "equal z kept colour", 32'(rb_color), 32'hA1);
    send2(2'b01, 3, 4, 101, 'hC3, 0, 0, 0, 0, t); flush();
    rb_chk("R2", 3, 4);
    send2(2'b01, 3, 4, 99, 'hD4, 0, 0, 0, 0, t); flush();
    rb_chk("R2", 3, 4);
    chk("R2", "nearer replaced", 32'(rb_color), 32'hD4);
  endtask

  // R3 eight fragments in four cycles, then a mixed second pass
  task automatic t_dual();
    int took_n = 0;
    bit t;
    for (int i = 0; i < 4; i++) begin
      send2(2'b11, i, 10, 200 + i, 'h100 + i, i + 8, 10, 300 - i, 'h200 + i, t);
      took_n += int'(t);
    end
    chk("R3", "pairs taken in 4 cycles", 32'(took_n), 32'd4);
    flush();
    for (int i = 0; i < 4; i++) begin
      rb_chk("R3", i, 10);
      rb_chk("R3", i + 8, 10);
    end
    for (int i = 0; i < 4; i++) begin
      send2(2'b11, i, 10, (i % 2 == 0) ? 150 : 250, 'h300 + i,
            i + 8, 10, (i % 2 == 0) ? 400 : 100, 'h400 + i, t);
    end
    flush();
    for (int i = 0; i < 4; i++) begin
      rb_chk("R3", i, 10);
      rb_chk("R3", i + 8, 10);
    end
  endtask

  // R4 idle lane carries nearer data but must not write
  task automatic t_mask();
    bit t;
    send2(2'b01, 5, 20, 500, 'h55, 20, 20, 5, 'h66, t);
    send2(2'b10, 21, 21, 5, 'h77, 6, 20, 600, 'h88, t);
    flush();
    rb_chk("R4", 20, 20);
    rb_chk("R4", 21, 21);
    rb_chk("R4", 5, 20);
    rb_chk("R4", 6, 20);
  endtask

  // R5 back-to-back same address
  task automatic t_hazard();
    bit t;
    send2(2'b01, 7, 30, 50, 'hE1, 0, 0, 0, 0, t);
    send2(2'b01, 7, 30, 60, 'hE2, 0, 0, 0, 0, t);
    flush();
    rb_chk("R5", 7, 30);
    chk("R5", "farther follower dropped", 32'(rb_z), 32'd50);
    send2(2'b01, 8, 30, 50, 'hF1, 0, 0, 0, 0, t);
    send2(2'b01, 8, 30, 40, 'hF2, 0, 0, 0, 0, t);
    flush();
    rb_chk("R5", 8, 30);
    send2(2'b11, 1, 31, 900, 'h11, 9, 30, 30, 'h21, t);
    send2(2'b11, 9, 30, 35, 'h31, 2, 31, 800, 'h41, t);
    flush();
    rb_chk("R5", 9, 30);
    chk("R5", "cross-lane follower dropped", 32'(rb_z), 32'd30);
    send2(2'b10, 0, 0, 0, 0, 10, 30, 70, 'h51, t);
    send2(2'b01, 10, 30, 90, 'h61, 0, 0, 0, 0, t);
    send2(2'b10, 0, 0, 0, 0, 10, 30, 80, 'h71, t);
    flush();
    rb_chk("R5", 10, 30);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (3) step();
    rst = 1'b0;
    step();
    t_reset();
    t_clear(1'b0);
    t_single();
    t_dual();
    t_mask();
    t_hazard();
    t_clear(1'b1);
    rb_chk("R6", 7, 30);
    rb_chk("R1", 3, 4);
    step();
    chk("R1", "rb_valid drops", 32'(rb_valid), 32'd0);
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end
endmodule